// File: doc/BRIEF.md
# Clock-Presence Watchdog Timer

This block is a watchdog timer that runs on its own slow clock and can serve as a monitor for the main system clock. In standard operation software keeps it alive by pulsing a kick input. If the kicks stop, the timeout raises a one-cycle interrupt, a reset, or an interrupt followed by a reset, depending on two mode bits.

A single pulse on the automatic-enable input switches the block into a sticky automatic mode. In that mode no software kicks are needed. A request/acknowledge toggle loop runs across the two clock domains. Each completed round trip proves that the system clock is alive, and it restarts the counter. If the system clock stops, the round trips stop too, and the counter runs out and drives the reset output. Automatic mode offers only the reset action and can be left only through a reset.

The counter length is set by a 4-bit prescale select and a base shift parameter. A sticky cause flag records that a watchdog reset has happened. All control inputs are sampled on the watchdog clock.

Top module: `clkmon_wdog`

## Requirements
- R1: After `rst` is released, `irq_o`, `wdrst_o` and `rst_flag_o` are low. With `std_en_i` low and no automatic command, neither output ever rises.
- R2: The timeout period is 2^(`psel_i`+BASE_SHIFT) watchdog clock cycles, counted from the cycle the watchdog starts running or from the last restart. With the default BASE_SHIFT of 11 and `psel_i`=0, this is 2048 cycles.
- R3: In standard mode, a one-cycle pulse on `kick_i` restarts the period. Regular kicks at intervals shorter than the period prevent any timeout.
- R4: In standard mode, `mode_i` selects the timeout action. 2'b00 gives an interrupt pulse only. 2'b01 or 2'b11 gives a reset only. 2'b10 gives an interrupt on the first timeout and a reset on the next one. A kick clears the pending interrupt stage. `irq_o` is high for exactly one cycle per interrupt.
- R5: A pulse on `auto_cmd_i` enters automatic mode and takes priority over `std_en_i` in the same cycle. In automatic mode, `kick_i`, `std_en_i` and `mode_i` have no effect.
- R6: In automatic mode, a system clock running at least four times faster than the watchdog clock keeps the counter from timing out.
- R7: In automatic mode, if the system clock stops, `wdrst_o` rises about one period later. `irq_o` never rises while automatic mode is active.
- R8: Automatic mode is left only through `rst` or through a watchdog reset. After a watchdog reset with `std_en_i` low, the watchdog stays idle.
- R9: Each watchdog reset holds `wdrst_o` high for exactly 4 watchdog clock cycles.
- R10: `rst_flag_o` rises together with `wdrst_o`. It is cleared by a pulse on `flag_clr_i` or by `rst`. If a set and a clear arrive in the same cycle, the set wins.
- R11: `psel_i` values above PSEL_MAX (default 9) give the same period as PSEL_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Watchdog clock; all control inputs are sampled on it |
| sys_clk | input | 1 | Monitored system clock |
| rst | input | 1 | Active-high reset, asynchronous assert, for both domains |
| kick_i | input | 1 | Software restart pulse (standard mode) |
| std_en_i | input | 1 | Standard watchdog enable level |
| mode_i | input | 2 | Standard-mode timeout action select |
| auto_cmd_i | input | 1 | One-cycle command entering automatic mode |
| psel_i | input | 4 | Prescale select for the timeout period |
| flag_clr_i | input | 1 | Clears the reset-cause flag |
| irq_o | output | 1 | One-cycle timeout interrupt |
| wdrst_o | output | 1 | Watchdog reset, 4 cycles wide |
| rst_flag_o | output | 1 | Sticky reset-cause flag |

## Verification
On every cycle, the assertions check the following:
- No interrupt appears while automatic mode is held.
- Automatic mode persists until a watchdog reset rises.
- Each reset pulse is exactly four cycles wide and sets the cause flag.
- Timeouts and interrupts never occur on back-to-back cycles.
- Detected clock activity pulses are isolated.

The bench scenarios are needed for the rest:
- The period length for several prescale values, including clamping.
- The three action encodings and the interrupt-then-reset sequence.
- Survival with a running system clock and timeout after that clock stops.
- Priority of the automatic command over the standard enable and kicks.
- The watchdog staying idle after a watchdog reset leaves automatic mode.

// File: rtl/wdm_pkg.sv
`timescale 1ns/1ps
package wdm_pkg;

    typedef enum logic [1:0] {
        ACT_IRQ     = 2'b00,
        ACT_RST     = 2'b01,
        ACT_IRQ_RST = 2'b10,
        ACT_RST_ALT = 2'b11
    } act_mode_e;

    typedef struct packed {
        logic irq;
        logic rst;
    } action_t;

    localparam int unsigned PULSE_LEN = 4;

    // Shift amount of the period: clamped prescale plus base.
    function automatic int unsigned term_shift(input logic [3:0] psel,
                                               input int unsigned base,
                                               input int unsigned pmax);
        int unsigned p;
        p = (int'(psel) > pmax) ? pmax : int'(psel);
        return p + base;
    endfunction

    // Action taken on a timeout.
    function automatic action_t pick_action(input logic auto_mode,
                                            input act_mode_e m,
                                            input logic armed);
        action_t a;
        a = '{irq: 1'b0, rst: 1'b1};
        if (!auto_mode) begin
            case (m)
                ACT_IRQ:     a = '{irq: 1'b1, rst: 1'b0};
                ACT_RST:     a = '{irq: 1'b0, rst: 1'b1};
                ACT_IRQ_RST: a = armed ? '{irq: 1'b0, rst: 1'b1}
                                       : '{irq: 1'b1, rst: 1'b0};
                default:     a = '{irq: 1'b0, rst: 1'b1};
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/wdm_actdet.sv
`timescale 1ns/1ps
module wdm_actdet (
    input  logic wd_clk,
    input  logic sys_clk,
    input  logic rst,
    output logic act_o
);
    localparam int unsigned SYNC_N = 2;

    logic              req_q;
    logic [SYNC_N-1:0] ack_sync;
    logic [SYNC_N-1:0] req_sync;
    logic              ack_q;

    // Request side: flips whenever the echo has caught up.
    always_ff @(posedge wd_clk or posedge rst) begin
        if (rst) begin
            req_q    <= 1'b0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_N-2:0], ack_q};
            if (act_o) req_q <= ~req_q;
        end
    end

    // Echo side in the monitored domain.
    always_ff @(posedge sys_clk or posedge rst) begin
        if (rst) begin
            req_sync <= '0;
            ack_q    <= 1'b0;
        end else begin
            req_sync <= {req_sync[SYNC_N-2:0], req_q};
            ack_q    <= req_sync[SYNC_N-1];
        end
    end

    assign act_o = (ack_sync[SYNC_N-1] == req_q);

    // R6
    act_isolated_chk: assert property (@(posedge wd_clk) disable iff (rst)
        act_o |=> !act_o);

endmodule

// File: rtl/wdm_timer.sv
`timescale 1ns/1ps
module wdm_timer
    import wdm_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 11,
    parameter int unsigned PSEL_MAX   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       reload,
    input  logic [3:0] psel,
    output logic       expire
);
    localparam int unsigned CW = BASE_SHIFT + PSEL_MAX;

    logic [CW-1:0] cnt;
    logic [CW-1:0] term;
    int unsigned   sh;

    always_comb begin
        sh   = term_shift(psel, BASE_SHIFT, PSEL_MAX);
        term = (CW'(1) << sh) - CW'(1);
    end

    assign expire = run && !reload && (cnt >= term);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                          cnt <= '0;
        else if (!run || reload || expire) cnt <= '0;
        else                              cnt <= cnt + CW'(1);
    end

    // R2
    expire_gap_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/wdm_pulse.sv
`timescale 1ns/1ps
module wdm_pulse
    import wdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                left_q <= '0;
        else if (fire && !busy) left_q <= PW'(PULSE_LEN);
        else if (busy)          left_q <= left_q - PW'(1);
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/clkmon_wdog.sv
`timescale 1ns/1ps
module clkmon_wdog
    import wdm_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 11,
    parameter int unsigned PSEL_MAX   = 9
) (
    input  logic       wd_clk,
    input  logic       sys_clk,
    input  logic       rst,
    input  logic       kick_i,
    input  logic       std_en_i,
    input  logic [1:0] mode_i,
    input  logic       auto_cmd_i,
    input  logic [3:0] psel_i,
    input  logic       flag_clr_i,
    output logic       irq_o,
    output logic       wdrst_o,
    output logic       rst_flag_o
);
    logic    auto_q, armed_q, irq_q, flag_q;
    logic    act, busy, expire, run, reload, eff_auto;
    logic    fire_irq, fire_rst;
    action_t action;

    wdm_actdet u_act (
        .wd_clk (wd_clk),
        .sys_clk(sys_clk),
        .rst    (rst),
        .act_o  (act)
    );

    assign eff_auto = auto_q | auto_cmd_i;
    assign run      = (auto_q | std_en_i) & ~busy;
    assign reload   = auto_q ? act : kick_i;

    wdm_timer #(.BASE_SHIFT(BASE_SHIFT), .PSEL_MAX(PSEL_MAX)) u_tmr (
        .clk   (wd_clk),
        .rst   (rst),
        .run   (run),
        .reload(reload),
        .psel  (psel_i),
        .expire(expire)
    );

    always_comb begin
        action   = pick_action(eff_auto, act_mode_e'(mode_i), armed_q);
        fire_irq = expire & action.irq;
        fire_rst = expire & action.rst;
    end

    wdm_pulse u_pls (
        .clk (wd_clk),
        .rst (rst),
        .fire(fire_rst),
        .busy(busy)
    );

    always_ff @(posedge wd_clk or posedge rst) begin
        if (rst) begin
            auto_q  <= 1'b0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (fire_rst)        auto_q <= 1'b0;
            else if (auto_cmd_i) auto_q <= 1'b1;

            if (fire_rst || !std_en_i || (!eff_auto && kick_i)) armed_q <= 1'b0;
            else if (fire_irq)                                  armed_q <= 1'b1;

            irq_q <= fire_irq;

            if (fire_rst)        flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign irq_o      = irq_q;
    assign wdrst_o    = busy;
    assign rst_flag_o = flag_q;

    // R7
    no_irq_auto_chk: assert property (@(posedge wd_clk) disable iff (rst)
        auto_q |-> !irq_o);

    // R8
    auto_sticky_chk: assert property (@(posedge wd_clk) disable iff (rst)
        auto_q |=> (auto_q || $rose(wdrst_o)));

    // R9
    rst_width_chk: assert property (@(posedge wd_clk) disable iff (rst)
        $rose(wdrst_o) |-> ##1 wdrst_o ##1 wdrst_o ##1 wdrst_o ##1 !wdrst_o);

    // R10
    flag_on_rst_chk: assert property (@(posedge wd_clk) disable iff (rst)
        $rose(wdrst_o) |-> rst_flag_o);

    // R4
    irq_pulse_chk: assert property (@(posedge wd_clk) disable iff (rst)
        irq_o |=> !irq_o);

endmodule

// File: tb/sim_clkmon_wdog.sv
`timescale 1ns/1ps
module sim_clkmon_wdog;
    localparam int unsigned BASE = 4;
    localparam int unsigned PMAX = 9;

    logic wd_clk = 1'b0, sys_clk = 1'b0, sys_run = 1'b1, rst = 1'b1;
    logic kick_i = 1'b0, std_en_i = 1'b0, auto_cmd_i = 1'b0, flag_clr_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] psel_i = 4'd0;
    logic irq_o, wdrst_o, rst_flag_o;

    int checks = 0, errors = 0, irq_seen = 0, rst_seen = 0;
    bit rst_prev = 1'b0, done = 1'b0;

    clkmon_wdog #(.BASE_SHIFT(BASE), .PSEL_MAX(PMAX)) u0 (
        .wd_clk(wd_clk), .sys_clk(sys_clk), .rst(rst), .kick_i(kick_i),
        .std_en_i(std_en_i), .mode_i(mode_i), .auto_cmd_i(auto_cmd_i),
        .psel_i(psel_i), .flag_clr_i(flag_clr_i), .irq_o(irq_o),
        .wdrst_o(wdrst_o), .rst_flag_o(rst_flag_o)
    );

    always #10 wd_clk = ~wd_clk;
    always #2 sys_clk = sys_run ? ~sys_clk : sys_clk;

    always @(negedge wd_clk) begin
        if (irq_o) irq_seen++;
        if (wdrst_o && !rst_prev) rst_seen++;
        rst_prev = wdrst_o;
    end

    function automatic int lim(input int p);
        return 1 << ((p > int'(PMAX) ? int'(PMAX) : p) + int'(BASE));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge wd_clk);
    endtask

    task automatic measure(input bit on_rst, input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge wd_clk);
            n++;
            if (on_rst ? wdrst_o : irq_o) break;
        end
    endtask

    task automatic t_reset();
        chk(!irq_o && !wdrst_o && !rst_flag_o, "R1 outputs after reset",
            {irq_o, wdrst_o, rst_flag_o}, 0);
        tick(100);
        chk(irq_seen == 0 && rst_seen == 0, "R1 idle when not enabled",
            irq_seen + rst_seen, 0);
    endtask

    task automatic t_period();
        int n;
        mode_i = 2'b00; psel_i = 4'd0; std_en_i = 1'b1;
        measure(1'b0, 200, n);
        chk(n >= lim(0) - 1 && n <= lim(0) + 3, "R2 period psel 0", n, lim(0) + 1);
        tick(1);
        chk(!irq_o, "R4 irq single cycle", irq_o, 0);
        std_en_i = 1'b0; tick(3);
        psel_i = 4'd2; std_en_i = 1'b1;
        measure(1'b0, 300, n);
        chk(n >= lim(2) - 1 && n <= lim(2) + 3, "R2 period psel 2", n, lim(2) + 1);
        std_en_i = 1'b0; tick(3);
    endtask

    task automatic t_kick();
        int n, base;
        mode_i = 2'b00; psel_i = 4'd2; std_en_i = 1'b1;
        base = irq_seen;
        for (int i = 0; i < 5; i++) begin
            tick(40);
            kick_i = 1'b1; tick(1); kick_i = 1'b0;
        end
        chk(irq_seen == base, "R3 kicks hold off timeout", irq_seen - base, 0);
        kick_i = 1'b1; tick(1); kick_i = 1'b0;
        measure(1'b0, 300, n);
        chk(n >= lim(2) - 2 && n <= lim(2) + 2, "R3 period after last kick", n, lim(2));
        std_en_i = 1'b0; tick(3);
    endtask

    task automatic t_rst_only();
        int n, bi, w;
        bi = irq_seen;
        mode_i = 2'b01; psel_i = 4'd0; std_en_i = 1'b1;
        measure(1'b1, 200, n);
        chk(n >= lim(0) - 1 && n <= lim(0) + 3, "R4 reset-only timeout", n, lim(0) + 1);
        std_en_i = 1'b0;
        chk(rst_flag_o, "R10 flag set with reset", rst_flag_o, 1);
        w = 1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (wdrst_o) w++; else break;
        end
        chk(w == 4, "R9 reset width", w, 4);
        chk(irq_seen == bi, "R4 no irq in reset-only", irq_seen - bi, 0);
        flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0; tick(1);
        chk(!rst_flag_o, "R10 flag cleared by write", rst_flag_o, 0);
        tick(3);
    endtask

    task automatic t_irq_rst();
        int n, br;
        br = rst_seen;
        mode_i = 2'b10; psel_i = 4'd0; std_en_i = 1'b1;
        measure(1'b0, 200, n);
        chk(n >= lim(0) - 1 && n <= lim(0) + 3, "R4 first stage irq", n, lim(0) + 1);
        chk(rst_seen == br, "R4 no reset at first stage", rst_seen - br, 0);
        measure(1'b1, 200, n);
        chk(n >= lim(0) - 2 && n <= lim(0) + 2, "R4 second stage reset", n, lim(0));
        std_en_i = 1'b0; tick(8);
        flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
    endtask

    task automatic t_clamp();
        int n;
        mode_i = 2'b00; psel_i = 4'd9; std_en_i = 1'b1;
        measure(1'b0, 9000, n);
        chk(n >= lim(9) - 1 && n <= lim(9) + 3, "R11 psel at max", n, lim(9) + 1);
        std_en_i = 1'b0; tick(3);
        psel_i = 4'd15; std_en_i = 1'b1;
        measure(1'b0, 9000, n);
        chk(n >= lim(9) - 1 && n <= lim(9) + 3, "R11 psel clamped", n, lim(9) + 1);
        std_en_i = 1'b0; tick(3);
    endtask

    task automatic t_auto();
        int n, br, bi;
        sys_run = 1'b1; psel_i = 4'd0; std_en_i = 1'b0;
        br = rst_seen; bi = irq_seen;
        auto_cmd_i = 1'b1; tick(1); auto_cmd_i = 1'b0;
        tick(300);
        chk(rst_seen == br, "R6 running clock keeps alive", rst_seen - br, 0);
        sys_run = 1'b0;
        measure(1'b1, 80, n);
        chk(wdrst_o && n >= lim(0) - 1 && n <= lim(0) + 12, "R7 reset after clock stop",
            n, lim(0) + 1);
        chk(irq_seen == bi, "R7 no irq in auto mode", irq_seen - bi, 0);
        tick(6);
        br = rst_seen;
        tick(5 * lim(0));
        chk(rst_seen == br, "R8 auto mode left after watchdog reset", rst_seen - br, 0);
        sys_run = 1'b1; tick(3);
        flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
    endtask

    task automatic t_priority();
        int n, br, bi;
        bit hit;
        sys_run = 1'b0; psel_i = 4'd0; mode_i = 2'b00;
        bi = irq_seen;
        std_en_i = 1'b1; auto_cmd_i = 1'b1; tick(1);
        auto_cmd_i = 1'b0; std_en_i = 1'b0;
        n = 0; hit = 1'b0;
        for (int i = 0; i < 80; i++) begin
            kick_i = (i % 3 == 0);
            @(negedge wd_clk);
            n++;
            if (wdrst_o) begin hit = 1'b1; break; end
        end
        kick_i = 1'b0;
        chk(hit && n >= lim(0) - 2 && n <= lim(0) + 4, "R5 auto wins, kicks ignored",
            n, lim(0));
        chk(irq_seen == bi, "R5 no irq despite standard enable", irq_seen - bi, 0);
        tick(6);
        br = rst_seen;
        tick(5 * lim(0));
        chk(rst_seen == br, "R8 idle after watchdog reset", rst_seen - br, 0);
        sys_run = 1'b1; tick(3);
    endtask

    task automatic t_flag_rst();
        int n;
        mode_i = 2'b01; psel_i = 4'd0; std_en_i = 1'b1;
        measure(1'b1, 200, n);
        std_en_i = 1'b0;
        tick(6);
        chk(rst_flag_o, "R10 flag held after pulse", rst_flag_o, 1);
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        chk(!rst_flag_o && !wdrst_o && !irq_o, "R10 flag cleared by reset",
            {irq_o, wdrst_o, rst_flag_o}, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_period();
        t_kick();
        t_rst_only();
        t_irq_rst();
        t_clamp();
        t_auto();
        t_priority();
        t_flag_rst();
        done = 1'b1;
        summary();
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

endmodule